// File: doc/BRIEF.md
# Pixel Input Format and OSD Selector

This block is the first stage behind the pixel pins of a digital video encoder. Each internal clock it takes one sample from three byte-wide buses. It turns that sample into an aligned three-channel word for the stages after it. A two-bit format select chooses how the buses are read:

- **Full RGB:** each bus carries one colour.
- **4:2:2 YUV:** the green bus carries luma and the blue bus carries U and V on alternate clocks.
- **Raw pass-through:** each byte is widened to nine bits for direct analog RGB output.

In YUV format the U/V alternation is locked to the line sync. The sample taken on the clock where the active-low horizontal sync first reads low is the U slot. A swap input reverses this. The last U and the last V are held, so every output word carries a complete luma/U/V triple.

An overlay source can replace the video with one of eight flat colours, chosen by a three-bit code. The override applies only while the timing generator reports active video, and it has no effect in pass-through format. All results are registered, with a latency of exactly one clock.

Top module: `pixel_front_select`

## Requirements
- R1: While the synchronous active-low reset is asserted, at the next edge all three output words, `outIsRgb` and `outValid` become zero.
- R2: With `fmtSel` = 00, the outputs one clock after a sample are `{inRed,0}`, `{inGreen,0}` and `{inBlue,0}` on A, B and C. `outIsRgb` and `outValid` are both 1.
- R3: With `fmtSel` = 01, output A is `{inGreen,0}` and `outIsRgb` is 0. The blue-bus byte is a U sample on slot 0 and a V sample on slot 1 (swap low). Slot 0 is the clock where `hsyncN` is low and was high on the previous clock. Otherwise the slot toggles every clock.
- R4: With `swapUv` high, slot 0 carries V and slot 1 carries U.
- R5: In YUV format, output B is `{U,0}` and output C is `{V,0}`. Each is the newest U or V sample, taken either from the current clock or from the last one held.
- R6: Reset sets the held U and V to midscale (`0x80` for 8-bit data) and makes the first sample after reset a slot-0 sample.
- R7: In format 00 or 01 with `osdEn` and `videoActive` both high, the output is an RGB colour: `outIsRgb` = 1 and `outValid` = 1. `osdCode[2]`, `osdCode[1]` and `osdCode[0]` set red, green and blue; each channel byte is all ones or all zeros, with bit 0 zero. Code 000 is black and 111 is white.
- R8: With `videoActive` low, `osdEn` has no effect on the output.
- R9: With `fmtSel` = 11, outputs A, B and C are `{inRed,osdCode[2]}`, `{inGreen,osdCode[1]}` and `{inBlue,osdCode[0]}`. `outIsRgb` = 1, and `osdEn` is ignored.
- R10: With `fmtSel` = 10, one clock later `outValid` = 0 and all output words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| fmtSel | input | 2 | Input format select |
| hsyncN | input | 1 | Horizontal sync, active low |
| swapUv | input | 1 | Reverse U/V slot order |
| videoActive | input | 1 | High during active video |
| osdEn | input | 1 | Overlay enable |
| osdCode | input | 3 | Overlay colour code: red, green, blue bits |
| inRed | input | DATA_W | Red byte |
| inGreen | input | DATA_W | Green byte or luma |
| inBlue | input | DATA_W | Blue byte or shared U/V |
| outA | output | DATA_W+1 | Red, luma, or pass-through red |
| outB | output | DATA_W+1 | Green, U, or pass-through green |
| outC | output | DATA_W+1 | Blue, V, or pass-through blue |
| outIsRgb | output | 1 | Output word is in RGB space |
| outValid | output | 1 | Output word is valid |

## Verification
The bench builds the block with the default 8-bit data width. At that width, random bytes cover the whole value range, and every one of the eight overlay codes can be exercised in a short run. Sync pulses are placed both periodically and at random. This covers slot restarts on odd and even phases, and format switches in the middle of a line. Held U/V values are tracked across those switches, so the hold path is checked whichever format came before.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    FMT_RGB  = 2'b00,
    FMT_YUV  = 2'b01,
    FMT_RSVD = 2'b10,
    FMT_PASS = 2'b11
  } fmt_e;

  localparam int NUM_CH = 3;

  typedef struct packed {
    logic valid;
    logic selPass;
    logic selOsd;
    logic selYuv;
    logic takeU;
    logic takeV;
  } strobe_t;

endpackage

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fmtSel,
  input  logic       hsyncN,
  input  logic       swapUv,
  input  logic       osdEn,
  input  logic       videoActive,
  output strobe_t    stb
);

  fmt_e fmt;
  logic prevH;
  logic nextSlot;
  logic fallNow;
  logic slotNow;

  assign fmt = fmt_e'(fmtSel);

  // Slot 0 restarts on the sync falling edge, otherwise the slot toggles.
  always_comb begin
    fallNow     = prevH & ~hsyncN;
    slotNow     = fallNow ? 1'b0 : nextSlot;
    stb.takeU   = ~(slotNow ^ swapUv);
    stb.takeV   = slotNow ^ swapUv;
    stb.valid   = (fmt != FMT_RSVD);
    stb.selPass = (fmt == FMT_PASS);
    stb.selOsd  = osdEn & videoActive & ((fmt == FMT_RGB) | (fmt == FMT_YUV));
    stb.selYuv  = (fmt == FMT_YUV) & ~stb.selOsd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevH    <= 1'b1;
      nextSlot <= 1'b0;
    end else begin
      prevH    <= hsyncN;
      nextSlot <= ~slotNow;
    end
  end

  // R3: without a sync fall the slot alternates every clock
  a_r3_alternate: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fallNow || (slotNow != $past(slotNow))));

  // R8: the overlay is never selected outside active video
  a_r8_blank_ignores_osd: assert property (@(posedge clk) disable iff (!rstN)
    !videoActive |-> !stb.selOsd);

  // R4: exactly one of the two chroma captures happens each clock
  a_r4_one_capture: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.takeU, stb.takeV}) == 1);

endmodule

// File: rtl/pfs_datapath.sv
module pfs_datapath
  import pfs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] inRed,
  input  logic [DATA_W-1:0] inGreen,
  input  logic [DATA_W-1:0] inBlue,
  input  logic [2:0]        osdCode,
  output logic [DATA_W:0]   outA,
  output logic [DATA_W:0]   outB,
  output logic [DATA_W:0]   outC,
  output logic              outIsRgb,
  output logic              outValid
);

  localparam int OUT_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] chIn   [NUM_CH];
  logic              osdBit [NUM_CH];
  logic [OUT_W-1:0]  rgbW   [NUM_CH];
  logic [OUT_W-1:0]  passW  [NUM_CH];
  logic [OUT_W-1:0]  osdW   [NUM_CH];
  logic [OUT_W-1:0]  yuvW   [NUM_CH];
  logic [OUT_W-1:0]  nxtW   [NUM_CH];
  logic [OUT_W-1:0]  outW   [NUM_CH];

  logic [DATA_W-1:0] heldU, heldV, uNew, vNew;
  logic              nxtRgb;

  assign chIn[0] = inRed;
  assign chIn[1] = inGreen;
  assign chIn[2] = inBlue;

  // Per-channel word builders: plain RGB, raw pass-through, overlay colour.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign osdBit[g] = osdCode[NUM_CH-1-g];
    assign rgbW[g]   = {chIn[g], 1'b0};
    assign passW[g]  = {chIn[g], osdBit[g]};
    assign osdW[g]   = {{DATA_W{osdBit[g]}}, 1'b0};
  end

  // Chroma demultiplex: the current byte, or the last one held.
  always_comb begin
    uNew    = stb.takeU ? inBlue : heldU;
    vNew    = stb.takeV ? inBlue : heldV;
    yuvW[0] = {inGreen, 1'b0};
    yuvW[1] = {uNew, 1'b0};
    yuvW[2] = {vNew, 1'b0};
  end

  always_comb begin
    nxtRgb = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!stb.valid) begin
        nxtW[i] = '0;
      end else if (stb.selPass) begin
        nxtW[i] = passW[i];
      end else if (stb.selOsd) begin
        nxtW[i] = osdW[i];
      end else if (stb.selYuv) begin
        nxtW[i] = yuvW[i];
      end else begin
        nxtW[i] = rgbW[i];
      end
    end
    if (stb.valid && !stb.selYuv) begin
      nxtRgb = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldU    <= MID;
      heldV    <= MID;
      outIsRgb <= 1'b0;
      outValid <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        outW[i] <= '0;
      end
    end else begin
      heldU    <= uNew;
      heldV    <= vNew;
      outIsRgb <= nxtRgb;
      outValid <= stb.valid;
      for (int i = 0; i < NUM_CH; i++) begin
        outW[i] <= nxtW[i];
      end
    end
  end

  assign outA = outW[0];
  assign outB = outW[1];
  assign outC = outW[2];

  // R10: an unused format never produces a valid word
  a_r10_unused_silent: assert property (@(posedge clk) disable iff (!rstN)
    !stb.valid |=> (!outValid && outA == '0 && outB == '0 && outC == '0));

  // R7: an overlay sample comes out as a valid RGB word
  a_r7_osd_is_rgb: assert property (@(posedge clk) disable iff (!rstN)
    stb.selOsd && !stb.selPass |=> (outIsRgb && outValid));

  // R9: pass-through keeps the overlay bit as the low bit
  a_r9_pass_lsb: assert property (@(posedge clk) disable iff (!rstN)
    stb.selPass |=> (outA[0] == $past(osdCode[2]) && outC[0] == $past(osdCode[0])));

  // R5: on a U slot, V output is the value held from before
  a_r5_hold_v: assert property (@(posedge clk) disable iff (!rstN)
    (stb.selYuv && stb.valid && stb.takeU) |=> (outC[DATA_W:1] == $past(heldV)));

endmodule

// File: rtl/pixel_front_select.sv
module pixel_front_select
  import pfs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fmtSel,
  input  logic              hsyncN,
  input  logic              swapUv,
  input  logic              videoActive,
  input  logic              osdEn,
  input  logic [2:0]        osdCode,
  input  logic [DATA_W-1:0] inRed,
  input  logic [DATA_W-1:0] inGreen,
  input  logic [DATA_W-1:0] inBlue,
  output logic [DATA_W:0]   outA,
  output logic [DATA_W:0]   outB,
  output logic [DATA_W:0]   outC,
  output logic              outIsRgb,
  output logic              outValid
);

  strobe_t stb;

  pfs_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fmtSel      (fmtSel),
    .hsyncN      (hsyncN),
    .swapUv      (swapUv),
    .osdEn       (osdEn),
    .videoActive (videoActive),
    .stb         (stb)
  );

  pfs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inRed    (inRed),
    .inGreen  (inGreen),
    .inBlue   (inBlue),
    .osdCode  (osdCode),
    .outA     (outA),
    .outB     (outB),
    .outC     (outC),
    .outIsRgb (outIsRgb),
    .outValid (outValid)
  );

endmodule

// File: tb/sim_pixel_front_select.sv
`timescale 1ns/1ps
module sim_pixel_front_select;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] fmtSel = 2'b00;
  logic       hsyncN = 1'b1;
  logic       swapUv = 1'b0;
  logic       videoActive = 1'b0;
  logic       osdEn = 1'b0;
  logic [2:0] osdCode = 3'b000;
  logic [7:0] inRed = 8'h00, inGreen = 8'h00, inBlue = 8'h00;
  logic [8:0] outA, outB, outC;
  logic       outIsRgb, outValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model state
  logic       mPrevH = 1'b1;
  logic       mNext  = 1'b0;
  logic [7:0] mU = 8'h80, mV = 8'h80;
  logic [8:0] eA, eB, eC;
  logic       eRgb, eVal;

  always #2.5 clk = ~clk;

  pixel_front_select #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .hsyncN(hsyncN), .swapUv(swapUv),
    .videoActive(videoActive), .osdEn(osdEn), .osdCode(osdCode),
    .inRed(inRed), .inGreen(inGreen), .inBlue(inBlue),
    .outA(outA), .outB(outB), .outC(outC), .outIsRgb(outIsRgb), .outValid(outValid)
  );

  function automatic logic [8:0] osdWord(input logic bitv);
    return {{8{bitv}}, 1'b0};
  endfunction

  task automatic predict();
    logic       fall, slot, isU;
    logic [7:0] nu, nv;
    if (!rstN) begin
      eA = '0; eB = '0; eC = '0; eRgb = 0; eVal = 0;
      mPrevH = 1'b1; mNext = 1'b0; mU = 8'h80; mV = 8'h80;
      return;
    end
    fall = mPrevH & ~hsyncN;
    slot = fall ? 1'b0 : mNext;
    isU  = (slot ^ swapUv) == 1'b0;
    nu   = isU ? inBlue : mU;
    nv   = isU ? mV : inBlue;
    if (fmtSel == 2'b10) begin
      eA = '0; eB = '0; eC = '0; eRgb = 0; eVal = 0;
    end else if (fmtSel == 2'b11) begin
      eA = {inRed, osdCode[2]}; eB = {inGreen, osdCode[1]}; eC = {inBlue, osdCode[0]};
      eRgb = 1; eVal = 1;
    end else if (osdEn && videoActive) begin
      eA = osdWord(osdCode[2]); eB = osdWord(osdCode[1]); eC = osdWord(osdCode[0]);
      eRgb = 1; eVal = 1;
    end else if (fmtSel == 2'b00) begin
      eA = {inRed, 1'b0}; eB = {inGreen, 1'b0}; eC = {inBlue, 1'b0};
      eRgb = 1; eVal = 1;
    end else begin
      eA = {inGreen, 1'b0}; eB = {nu, 1'b0}; eC = {nv, 1'b0};
      eRgb = 0; eVal = 1;
    end
    mU = nu; mV = nv; mPrevH = hsyncN; mNext = ~slot;
  endtask

  task automatic cyc(input string tag);
    logic [28:0] act, exp;
    predict();
    @(posedge clk);
    #1;
    act = {outValid, outIsRgb, outA, outB, outC};
    exp = {eVal, eRgb, eA, eB, eC};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (valid,rgb,A,B,C)", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] f, input logic [7:0] r, g, b,
                       input logic [2:0] oc, input logic oe, act, sw, hs);
    fmtSel = f; inRed = r; inGreen = g; inBlue = b;
    osdCode = oc; osdEn = oe; videoActive = act; swapUv = sw; hsyncN = hs;
  endtask

  function automatic string tagFor(input logic [1:0] f, input logic oe, act);
    if (f == 2'b10) return "R10";
    if (f == 2'b11) return "R9";
    if (oe && act)  return "R7";
    if (oe)         return "R8";
    if (f == 2'b00) return "R2";
    return "R5";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    rstN = 0;
    drive(2'b00, 8'hA5, 8'h5A, 8'h3C, 3'b111, 1, 1, 0, 1);
    repeat (3) cyc("R1");
    rstN = 1;
    // R6: first sample is a U slot, V still midscale
    drive(2'b01, 8'h00, 8'h40, 8'h11, 3'b000, 0, 1, 0, 1);
    cyc("R6");
    drive(2'b01, 8'h00, 8'h41, 8'h22, 3'b000, 0, 1, 0, 1);
    cyc("R5");
    // R2: RGB patterns
    drive(2'b00, 8'hFF, 8'h00, 8'h80, 3'b101, 0, 1, 0, 1); cyc("R2");
    drive(2'b00, 8'h01, 8'hFE, 8'h7F, 3'b000, 0, 0, 0, 1); cyc("R2");
    // R3: sync fall restarts slot 0 even on an odd phase
    drive(2'b01, 8'h00, 8'h10, 8'h33, 3'b000, 0, 1, 0, 1); cyc("R3");
    drive(2'b01, 8'h00, 8'h11, 8'h44, 3'b000, 0, 1, 0, 0); cyc("R3");
    drive(2'b01, 8'h00, 8'h12, 8'h55, 3'b000, 0, 1, 0, 0); cyc("R3");
    drive(2'b01, 8'h00, 8'h13, 8'h66, 3'b000, 0, 1, 0, 0); cyc("R3");
    // R4: swap reverses the slot roles
    drive(2'b01, 8'h00, 8'h20, 8'hC1, 3'b000, 0, 1, 1, 1); cyc("R4");
    drive(2'b01, 8'h00, 8'h21, 8'hC2, 3'b000, 0, 1, 1, 0); cyc("R4");
    drive(2'b01, 8'h00, 8'h22, 8'hC3, 3'b000, 0, 1, 1, 0); cyc("R4");
    // R7: all overlay codes in both formats
    for (int k = 0; k < 8; k++) begin
      drive(2'b00, 8'h5A, 8'h5A, 8'h5A, 3'(k), 1, 1, 0, 1); cyc("R7");
      drive(2'b01, 8'h5A, 8'h5A, 8'h5A, 3'(k), 1, 1, 0, 1); cyc("R7");
    end
    // R8: overlay ignored outside active video
    drive(2'b00, 8'h12, 8'h34, 8'h56, 3'b111, 1, 0, 0, 1); cyc("R8");
    drive(2'b01, 8'h12, 8'h34, 8'h56, 3'b000, 1, 0, 0, 1); cyc("R8");
    // R9: pass-through with overlay bits, enable ignored
    drive(2'b11, 8'hAB, 8'hCD, 8'hEF, 3'b101, 1, 1, 0, 1); cyc("R9");
    drive(2'b11, 8'h01, 8'h02, 8'h03, 3'b010, 0, 0, 0, 1); cyc("R9");
    // R10: unused code
    drive(2'b10, 8'hFF, 8'hFF, 8'hFF, 3'b111, 1, 1, 0, 1); cyc("R10");
    // R6: reset mid-run restores phase and midscale
    drive(2'b01, 8'h00, 8'h50, 8'h77, 3'b000, 0, 1, 0, 1); cyc("R5");
    rstN = 0; cyc("R1");
    rstN = 1;
    drive(2'b01, 8'h00, 8'h51, 8'h99, 3'b000, 0, 1, 0, 1); cyc("R6");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] f;
      logic oe, act, sw, hs;
      f   = 2'($urandom);
      oe  = ($urandom % 4) == 0;
      act = ($urandom % 3) != 0;
      sw  = (f == 2'b01) ? 1'($urandom) : 1'b0;
      hs  = ((n % 37) < 3) ? 1'b0 : (($urandom % 50) != 0);
      drive(f, 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), oe, act, sw, hs);
      cyc(tagFor(f, oe, act));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule